// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces one data address per cycle from a small set of address registers. It holds four index registers, four modify registers, four base registers and four length registers. Each requested operation names one index register and, for modify operations, one modify register. The block returns the current value of that index as the memory address. In the same clock edge it writes back the updated index.

The index can move up or down by a fixed access size of 4 bytes (word) or 2 bytes (halfword). It can also move by the amount held in a modify register, added or subtracted. When the length register paired with the index is non-zero, the updated index is kept inside the window from base up to base plus length, wrapping at either end. A length of zero gives plain linear addressing.

All registers are loaded through one write port. A write selects a register file and an entry within it. Loading a base register never alters the index register paired with it.

Top module: `addr_gen_circ`

## Requirements
- R1: After synchronous reset every index, modify, base and length register reads as zero and `addr_valid` is low.
- R2: When `op_valid` is high, `addr_valid` is high on the next cycle and `addr_out` holds the value the selected index had before its update (post-modify). When `op_valid` is low, `addr_valid` is low on the next cycle.
- R3: The fixed-step op codes are: 3'd1 adds 4, 3'd2 subtracts 4, 3'd3 adds 2 and 3'd4 subtracts 2. Each updates index `op_idx`.
- R4: Op code 3'd5 adds modify register `op_mod` to index `op_idx`. Op code 3'd6 subtracts modify register `op_mod` from index `op_idx`.
- R5: With a non-zero length, an updated value at or above base plus length has the length subtracted from it.
- R6: With a non-zero length, an updated value below base has the length added to it.
- R7: With a length of zero, the update is linear, modulo 2^AW.
- R8: Writing a base register leaves the index register with the same number unchanged.
- R9: Op codes 3'd0 and 3'd7 output the address but leave the index unchanged.
- R10: If a register write and an update hit the same index in one cycle, the written value is kept. A modify register written in the same cycle as it is used contributes its old value.
- R11: A register write is selected by `wr_file`: 0 = index, 1 = modify, 2 = base, 3 = length. The entry is chosen by `wr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_file | input | 2 | Target register file (0 index, 1 modify, 2 base, 3 length) |
| wr_sel | input | 2 | Entry within the file |
| wr_data | input | AW | Value written |
| op_valid | input | 1 | Address request this cycle |
| op_code | input | 3 | Update kind (see R3, R4, R9) |
| op_idx | input | 2 | Index register (and its base/length pair) used |
| op_mod | input | 2 | Modify register used by op codes 5 and 6 |
| addr_valid | output | 1 | Registered: address request accepted last cycle |
| addr_out | output | AW | Registered pre-update index value |

## Verification
The window assertion assumes that the selected index already lies inside its base/length window. It also assumes a length of at least 4 and that base plus length does not exceed the address range. A single add or subtract can only correct by one length, so the assertion holds only under these conditions. The stimulus programs each circular buffer before using it, places the index inside the window, and uses modify amounts no larger than the length. Linear wrap past 2^AW is exercised only with a length of zero, where no window applies.

// File: rtl/dagc_pkg.sv
package dagc_pkg;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INC4 = 3'd1,
    OP_DEC4 = 3'd2,
    OP_INC2 = 3'd3,
    OP_DEC2 = 3'd4,
    OP_ADDM = 3'd5,
    OP_SUBM = 3'd6,
    OP_RSVD = 3'd7
  } dag_op_e;

  typedef enum logic [1:0] {
    RF_IDX  = 2'd0,
    RF_MOD  = 2'd1,
    RF_BASE = 2'd2,
    RF_LEN  = 2'd3
  } dag_file_e;

  function automatic logic op_updates(input dag_op_e op);
    return (op != OP_HOLD) && (op != OP_RSVD);
  endfunction

endpackage

// File: rtl/dagc_bank.sv
module dagc_bank #(
  parameter int AW      = 32,
  parameter int NREG    = 4,
  parameter bit HAS_UPD = 1'b0,
  localparam int SW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_sel,
  input  logic [AW-1:0] upd_data,
  input  logic [SW-1:0] rd_sel,
  output logic [AW-1:0] rd_data
);

  logic [AW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic wr_hit, upd_hit;
    assign wr_hit  = wr_en && (wr_sel == SW'(g));
    assign upd_hit = HAS_UPD && upd_en && (upd_sel == SW'(g));

    always_ff @(posedge clk) begin
      if (rst)          regs[g] <= '0;
      else if (wr_hit)  regs[g] <= wr_data;
      else if (upd_hit) regs[g] <= upd_data;
    end
  end

  assign rd_data = regs[rd_sel];

endmodule

// File: rtl/dagc_step.sv
module dagc_step
  import dagc_pkg::*;
#(
  parameter int AW = 32
) (
  input  dag_op_e       op,
  input  logic [AW-1:0] mod_val,
  output logic [AW-1:0] step,
  output logic          step_sub
);

  always_comb begin
    step     = '0;
    step_sub = 1'b0;
    unique case (op)
      OP_INC4: step = AW'(4);
      OP_DEC4: begin step = AW'(4); step_sub = 1'b1; end
      OP_INC2: step = AW'(2);
      OP_DEC2: begin step = AW'(2); step_sub = 1'b1; end
      OP_ADDM: step = mod_val;
      OP_SUBM: begin step = mod_val; step_sub = 1'b1; end
      default: step = '0;
    endcase
  end

endmodule

// File: rtl/dagc_wrap.sv
module dagc_wrap #(
  parameter int AW = 32,
  localparam int EW = AW + 2
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] step,
  input  logic          step_sub,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);

  logic signed [EW-1:0] raw, lo, hi, lenx, up, dn;

  always_comb begin
    lenx = $signed({2'b00, len});
    lo   = $signed({2'b00, base});
    hi   = lo + lenx;
    raw  = step_sub ? ($signed({2'b00, idx}) - $signed({2'b00, step}))
                    : ($signed({2'b00, idx}) + $signed({2'b00, step}));
    up   = raw + lenx;
    dn   = raw - lenx;
    if (len == '0)       nxt = raw[AW-1:0];
    else if (raw < lo)   nxt = up[AW-1:0];
    else if (raw >= hi)  nxt = dn[AW-1:0];
    else                 nxt = raw[AW-1:0];
  end

endmodule

// File: rtl/addr_gen_circ.sv
module addr_gen_circ
  import dagc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_file,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [SW-1:0] op_idx,
  input  logic [SW-1:0] op_mod,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out
);

  dag_op_e       op;
  logic [AW-1:0] cur_idx, cur_mod, cur_base, cur_len;
  logic [AW-1:0] step, upd_val;
  logic          step_sub, upd_en;
  logic          we_idx, we_mod, we_base, we_len;

  assign op      = dag_op_e'(op_code);
  assign upd_en  = op_valid && op_updates(op);
  assign we_idx  = wr_en && (wr_file == RF_IDX);
  assign we_mod  = wr_en && (wr_file == RF_MOD);
  assign we_base = wr_en && (wr_file == RF_BASE);
  assign we_len  = wr_en && (wr_file == RF_LEN);

  dagc_bank #(.AW(AW), .NREG(NREG), .HAS_UPD(1'b1)) u_idx (
    .clk, .rst, .wr_en(we_idx), .wr_sel, .wr_data,
    .upd_en, .upd_sel(op_idx), .upd_data(upd_val),
    .rd_sel(op_idx), .rd_data(cur_idx));

  dagc_bank #(.AW(AW), .NREG(NREG), .HAS_UPD(1'b0)) u_mod (
    .clk, .rst, .wr_en(we_mod), .wr_sel, .wr_data,
    .upd_en(1'b0), .upd_sel(op_idx), .upd_data(upd_val),
    .rd_sel(op_mod), .rd_data(cur_mod));

  dagc_bank #(.AW(AW), .NREG(NREG), .HAS_UPD(1'b0)) u_base (
    .clk, .rst, .wr_en(we_base), .wr_sel, .wr_data,
    .upd_en(1'b0), .upd_sel(op_idx), .upd_data(upd_val),
    .rd_sel(op_idx), .rd_data(cur_base));

  dagc_bank #(.AW(AW), .NREG(NREG), .HAS_UPD(1'b0)) u_len (
    .clk, .rst, .wr_en(we_len), .wr_sel, .wr_data,
    .upd_en(1'b0), .upd_sel(op_idx), .upd_data(upd_val),
    .rd_sel(op_idx), .rd_data(cur_len));

  dagc_step #(.AW(AW)) u_step (
    .op, .mod_val(cur_mod), .step, .step_sub);

  dagc_wrap #(.AW(AW)) u_wrap (
    .idx(cur_idx), .step, .step_sub, .base(cur_base), .len(cur_len),
    .nxt(upd_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= op_valid;
      if (op_valid) addr_out <= cur_idx;
    end
  end

endmodule

// File: rtl/dagc_chk.sv
module dagc_chk #(
  parameter int AW = 32,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic          addr_valid,
  input logic [AW-1:0] addr_out,
  input logic          upd_en,
  input logic [AW-1:0] upd_val,
  input logic [AW-1:0] cur_idx,
  input logic [AW-1:0] cur_base,
  input logic [AW-1:0] cur_len
);

  logic [AW:0] win_hi;
  logic        in_win, fixed_step;
  assign win_hi     = {1'b0, cur_base} + {1'b0, cur_len};
  assign in_win     = ({1'b0, cur_idx} >= {1'b0, cur_base}) && ({1'b0, cur_idx} < win_hi);
  assign fixed_step = (op_code >= 3'd1) && (op_code <= 3'd4);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !addr_valid);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> addr_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !addr_valid);

  // R2
  post_modify_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> addr_out == $past(cur_idx));

  // R9
  hold_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 3'd0 || op_code == 3'd7)) |-> !upd_en);

  // R5
  window_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && fixed_step && cur_len >= AW'(4) && !win_hi[AW] && in_win)
      |-> ({1'b0, upd_val} >= {1'b0, cur_base} && {1'b0, upd_val} < win_hi));

  // R7
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op_code == 3'd1 && cur_len == '0) |-> upd_val == cur_idx + AW'(4));

endmodule

bind addr_gen_circ dagc_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .addr_valid(addr_valid), .addr_out(addr_out),
  .upd_en(upd_en), .upd_val(upd_val), .cur_idx(cur_idx),
  .cur_base(cur_base), .cur_len(cur_len));

// File: tb/addr_gen_circ_tb.sv
module addr_gen_circ_tb;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_file = '0;
  logic [1:0]    wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = '0;
  logic [1:0]    op_idx = '0;
  logic [1:0]    op_mod = '0;
  logic          addr_valid;
  logic [AW-1:0] addr_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  addr_gen_circ #(.AW(AW), .NREG(4)) u_dut (
    .clk, .rst, .wr_en, .wr_file, .wr_sel, .wr_data,
    .op_valid, .op_code, .op_idx, .op_mod, .addr_valid, .addr_out);

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] f, input logic [1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_file = f; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // issue one op, return the address seen one cycle later
  task automatic do_op(input logic [2:0] c, input logic [1:0] i, input logic [1:0] m,
                       output logic [AW-1:0] a);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_idx = i; op_mod = m;
    @(negedge clk);
    op_valid = 1'b0;
    a = addr_out;
    chk("R2 addr_valid", {31'd0, addr_valid}, 32'd1);
  endtask

  task automatic peek(input string tag, input logic [1:0] i, input logic [AW-1:0] exp);
    logic [AW-1:0] a;
    do_op(3'd0, i, 2'd0, a);
    chk(tag, a, exp);
  endtask

  task automatic t_reset;
    chk("R1 addr_valid", {31'd0, addr_valid}, 32'd0);
    for (int k = 0; k < 4; k++) peek("R1 index zero", k[1:0], '0);
    @(negedge clk);
    chk("R2 valid drops", {31'd0, addr_valid}, 32'd0);
  endtask

  task automatic t_steps;
    logic [AW-1:0] a;
    wreg(2'd0, 2'd0, 32'h100);            // R11 index file
    do_op(3'd1, 2'd0, 2'd0, a); chk("R2 pre-update addr", a, 32'h100);
    peek("R3 +4", 2'd0, 32'h104);
    do_op(3'd4, 2'd0, 2'd0, a); peek("R3 -2", 2'd0, 32'h102);
    do_op(3'd3, 2'd0, 2'd0, a); peek("R3 +2", 2'd0, 32'h104);
    do_op(3'd2, 2'd0, 2'd0, a); peek("R3 -4", 2'd0, 32'h100);
  endtask

  task automatic t_modify;
    logic [AW-1:0] a;
    wreg(2'd1, 2'd1, 32'h30);              // R11 modify file
    wreg(2'd0, 2'd1, 32'h200);
    do_op(3'd5, 2'd1, 2'd1, a); chk("R4 addM addr", a, 32'h200);
    peek("R4 +M", 2'd1, 32'h230);
    do_op(3'd6, 2'd1, 2'd1, a); peek("R4 -M", 2'd1, 32'h200);
  endtask

  task automatic t_circ;
    logic [AW-1:0] a;
    wreg(2'd0, 2'd2, 32'h100C);
    wreg(2'd2, 2'd2, 32'h1000);
    peek("R8 base write keeps index", 2'd2, 32'h100C);
    wreg(2'd3, 2'd2, 32'h10);
    do_op(3'd1, 2'd2, 2'd0, a); chk("R5 addr before wrap", a, 32'h100C);
    peek("R5 wrap at top", 2'd2, 32'h1000);
    do_op(3'd4, 2'd2, 2'd0, a); peek("R6 wrap at bottom", 2'd2, 32'h100E);
    wreg(2'd1, 2'd3, 32'hC);
    do_op(3'd5, 2'd2, 2'd3, a); peek("R5 modify wrap", 2'd2, 32'h100A);
    do_op(3'd6, 2'd2, 2'd3, a); peek("R6 modify wrap", 2'd2, 32'h100E);
  endtask

  task automatic t_linear;
    logic [AW-1:0] a;
    wreg(2'd0, 2'd3, 32'hFFFF_FFFE);
    do_op(3'd1, 2'd3, 2'd0, a); peek("R7 linear modulo", 2'd3, 32'h2);
    do_op(3'd2, 2'd3, 2'd0, a); peek("R7 linear back", 2'd3, 32'hFFFF_FFFE);
  endtask

  task automatic t_noupd;
    logic [AW-1:0] a;
    do_op(3'd7, 2'd0, 2'd0, a); chk("R9 code7 addr", a, 32'h100);
    peek("R9 code7 no change", 2'd0, 32'h100);
    do_op(3'd0, 2'd0, 2'd0, a); peek("R9 code0 no change", 2'd0, 32'h100);
  endtask

  task automatic t_collide;
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd1; op_idx = 2'd0; op_mod = 2'd0;
    wr_en = 1'b1; wr_file = 2'd0; wr_sel = 2'd0; wr_data = 32'h500;
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0;
    chk("R10 collide addr", addr_out, 32'h100);
    peek("R10 write wins", 2'd0, 32'h500);
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd5; op_idx = 2'd1; op_mod = 2'd1;
    wr_en = 1'b1; wr_file = 2'd1; wr_sel = 2'd1; wr_data = 32'h99;
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0;
    peek("R10 old modify used", 2'd1, 32'h230);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_steps;
    t_modify;
    t_circ;
    t_linear;
    t_noupd;
    t_collide;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule